// File: doc/BRIEF.md
# Flash Controller Interrupt Aggregator

This block gathers the event sources of a serial flash controller into one interrupt line. Pulses from the descriptor engine (descriptor done, packet complete, DMA error) and from a controller soft reset, together with conditions derived from the transmit and receive FIFO fill levels, each set a sticky bit in a status register. A set bit stays set until software writes a one to it. A set bit only reaches the interrupt line if it is enabled in two separate mask registers: the enable register and the signal enable register.

The FIFO conditions are empty, full and threshold. They come from the two fill-level inputs and a threshold register with one 5-bit field per direction. A handler normally reads the status register, which has no side effects. It then either clears the bits it has dealt with, or clears the matching enable bits so that a sticky source stops driving the line.

Top module: `flash_irq_hub`

## Requirements
- R1: After synchronous reset, the status, enable, signal enable and threshold registers read 0, and `irq_o` is low.
- R2: A one-cycle pulse on `evt_desc_done`, `evt_pkt_done` or `evt_dma_err` sets status bit 9, 10 or 11 respectively. The bit stays set after the pulse ends.
- R3: Status bits latch whatever the enable and signal enable settings are. With either mask at zero, `irq_o` stays low.
- R4: `irq_o` is high exactly when some status bit is also set in both the enable register (address 1) and the signal enable register (address 2). It follows the register state one clock later.
- R5: Writing the status register (address 0) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R6: If a set event and a write-one-to-clear hit the same bit in the same cycle, the bit ends set.
- R7: Clearing an enable bit drops `irq_o` while the status bit stays set. Setting it again raises `irq_o` again.
- R8: Status bit 0 sets when `tx_level` is 0 and bit 1 when `tx_level` equals FIFO_DEPTH. Bit 3 sets when `rx_level` is 0 and bit 4 when `rx_level` equals FIFO_DEPTH.
- R9: With a nonzero threshold, bit 2 sets when `tx_level` is less than or equal to the TX field, and bit 5 sets when `rx_level` is greater than or equal to the RX field. Both comparisons include equality.
- R10: The threshold register (address 3) holds the TX field at bits 12:8 and the RX field at bits 4:0, and all other bits read 0. A field of zero disables that threshold event.
- R11: A pulse on `evt_soft_rst` sets both FIFO-empty bits (bits 0 and 3).
- R12: Reading any register has no side effect. Back-to-back reads of the status register return the same value.
- R13: The enable and signal enable registers store only the nine mapped bits (mask 0xE3F), and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address: 0 status, 1 enable, 2 signal enable, 3 threshold |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data for `reg_addr` from the previous cycle |
| evt_desc_done | input | 1 | Descriptor finished pulse |
| evt_pkt_done | input | 1 | Packet finished pulse |
| evt_dma_err | input | 1 | DMA error pulse |
| evt_soft_rst | input | 1 | Controller soft reset pulse |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The gating is tried with each mask alone and with both masks together, which separates a two-mask AND from a single mask or an OR. The clear path is exercised three ways:
- an all-zero write, which must change nothing;
- a partial write, which must touch only the selected bits;
- a clear that lands in the same cycle as a new event, which distinguishes set-priority from clear-priority.

Fill levels are stepped to 0, to full, to exactly the threshold and to one step short of it, with zero thresholds as well. This separates inclusive from exclusive comparisons and shows that a zero field disables its event.

// File: rtl/fih_pkg.sv
package fih_pkg;
  localparam int unsigned ST_W   = 12;
  localparam int unsigned B_TXE  = 0;
  localparam int unsigned B_TXF  = 1;
  localparam int unsigned B_TXT  = 2;
  localparam int unsigned B_RXE  = 3;
  localparam int unsigned B_RXF  = 4;
  localparam int unsigned B_RXT  = 5;
  localparam int unsigned B_DESC = 9;
  localparam int unsigned B_PKT  = 10;
  localparam int unsigned B_DERR = 11;
  localparam logic [ST_W-1:0] ST_IMPL = 12'hE3F;

  typedef enum logic [1:0] {
    RA_STAT = 2'd0,
    RA_EN   = 2'd1,
    RA_SIG  = 2'd2,
    RA_THR  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/fih_level_cmp.sv
module fih_level_cmp #(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned LVL_W      = 5,
  parameter int unsigned THR_W      = 5,
  parameter bit          IS_TX      = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level,
  input  logic [THR_W-1:0] thr,
  output logic             is_empty,
  output logic             is_full,
  output logic             thr_hit
);
  localparam int unsigned CW = (LVL_W > THR_W) ? LVL_W : THR_W;

  logic [CW-1:0] lvl_x;
  logic [CW-1:0] thr_x;

  assign lvl_x    = CW'(level);
  assign thr_x    = CW'(thr);
  assign is_empty = (level == '0);
  assign is_full  = (lvl_x == CW'(FIFO_DEPTH));

  generate
    if (IS_TX) begin : g_tx
      assign thr_hit = (thr != '0) && (lvl_x <= thr_x);
    end else begin : g_rx
      assign thr_hit = (thr != '0) && (lvl_x >= thr_x);
    end
  endgenerate

  // R10: a zero field never yields a threshold event
  assert_zero_thr_R10: assert property (@(posedge clk) disable iff (rst)
    (thr == '0) |-> !thr_hit);
endmodule

// File: rtl/fih_status_bank.sv
module fih_status_bank
  import fih_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] set_v,
  input  logic [ST_W-1:0] clr_v,
  output logic [ST_W-1:0] stat_q
);
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= ((stat_q & ~clr_v) | set_v) & ST_IMPL;
  end

  // R2: a set bit not cleared stays set
  assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(stat_q) & ~$past(clr_v) & ~stat_q) == '0));

  // R6: an event wins over a clear in the same cycle
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (|(set_v & ST_IMPL)) |=> ((stat_q & $past(set_v & ST_IMPL)) == $past(set_v & ST_IMPL)));

  // R5: cleared bits with no concurrent event read zero
  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    ((|clr_v) && !(|set_v)) |=> ((stat_q & $past(clr_v)) == '0));
endmodule

// File: rtl/flash_irq_hub.sv
module flash_irq_hub
  import fih_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned AW         = 2,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1),
  parameter int unsigned THR_W      = 5,
  parameter int unsigned TX_THR_LSB = 8,
  parameter int unsigned RX_THR_LSB = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             evt_desc_done,
  input  logic             evt_pkt_done,
  input  logic             evt_dma_err,
  input  logic             evt_soft_rst,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  output logic             irq_o
);
  logic [ST_W-1:0]  stat;
  logic [ST_W-1:0]  en_q;
  logic [ST_W-1:0]  sig_q;
  logic [THR_W-1:0] tx_thr_q;
  logic [THR_W-1:0] rx_thr_q;
  logic [ST_W-1:0]  set_v;
  logic [ST_W-1:0]  clr_v;
  logic tx_e, tx_f, tx_t, rx_e, rx_f, rx_t;
  logic wr_stat, wr_en, wr_sig, wr_thr;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign wr_stat = reg_wr && (reg_addr == AW'(RA_STAT));
  assign wr_en   = reg_wr && (reg_addr == AW'(RA_EN));
  assign wr_sig  = reg_wr && (reg_addr == AW'(RA_SIG));
  assign wr_thr  = reg_wr && (reg_addr == AW'(RA_THR));

  fih_level_cmp #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .THR_W(THR_W), .IS_TX(1'b1)) u_tx_cmp (
    .clk(clk), .rst(rst), .level(tx_level), .thr(tx_thr_q),
    .is_empty(tx_e), .is_full(tx_f), .thr_hit(tx_t));

  fih_level_cmp #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .THR_W(THR_W), .IS_TX(1'b0)) u_rx_cmp (
    .clk(clk), .rst(rst), .level(rx_level), .thr(rx_thr_q),
    .is_empty(rx_e), .is_full(rx_f), .thr_hit(rx_t));

  always_comb begin
    set_v         = '0;
    set_v[B_TXE]  = tx_e | evt_soft_rst;
    set_v[B_TXF]  = tx_f;
    set_v[B_TXT]  = tx_t;
    set_v[B_RXE]  = rx_e | evt_soft_rst;
    set_v[B_RXF]  = rx_f;
    set_v[B_RXT]  = rx_t;
    set_v[B_DESC] = evt_desc_done;
    set_v[B_PKT]  = evt_pkt_done;
    set_v[B_DERR] = evt_dma_err;
    clr_v         = wr_stat ? reg_wdata[ST_W-1:0] : '0;
  end

  fih_status_bank u_bank (
    .clk(clk), .rst(rst), .set_v(set_v), .clr_v(clr_v), .stat_q(stat));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      sig_q    <= '0;
      tx_thr_q <= '0;
      rx_thr_q <= '0;
      irq_o    <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (wr_en)  en_q  <= reg_wdata[ST_W-1:0] & ST_IMPL;
      if (wr_sig) sig_q <= reg_wdata[ST_W-1:0] & ST_IMPL;
      if (wr_thr) begin
        tx_thr_q <= reg_wdata[TX_THR_LSB +: THR_W];
        rx_thr_q <= reg_wdata[RX_THR_LSB +: THR_W];
      end
      irq_o <= |(stat & en_q & sig_q);
      reg_rdata <= '0;
      case (reg_sel_e'(reg_addr[1:0]))
        RA_STAT: reg_rdata <= DW'(stat);
        RA_EN:   reg_rdata <= DW'(en_q);
        RA_SIG:  reg_rdata <= DW'(sig_q);
        default: begin
          reg_rdata[TX_THR_LSB +: THR_W] <= tx_thr_q;
          reg_rdata[RX_THR_LSB +: THR_W] <= rx_thr_q;
        end
      endcase
    end
  end

  // R4 / R3: without an overlap in either mask the line stays low
  assert_en_gate_R4: assert property (@(posedge clk) disable iff (rst)
    !(|(stat & en_q)) |=> !irq_o);
  assert_sig_gate_R4: assert property (@(posedge clk) disable iff (rst)
    !(|(stat & sig_q)) |=> !irq_o);
  // R13: unmapped mask bits never hold a one
  assert_mask_bits_R13: assert property (@(posedge clk) disable iff (rst)
    ((en_q & ~ST_IMPL) == '0) && ((sig_q & ~ST_IMPL) == '0));
endmodule

// File: tb/flash_irq_hub_test.sv
module flash_irq_hub_test;
  localparam int DEPTH = 16;
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic evt_desc_done = 1'b0, evt_pkt_done = 1'b0, evt_dma_err = 1'b0, evt_soft_rst = 1'b0;
  logic [LW-1:0] tx_level = LW'(5);
  logic [LW-1:0] rx_level = LW'(3);
  logic irq_o;

  always #10ns clk = ~clk;

  flash_irq_hub #(.FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_desc_done(evt_desc_done), .evt_pkt_done(evt_pkt_done),
    .evt_dma_err(evt_dma_err), .evt_soft_rst(evt_soft_rst),
    .tx_level(tx_level), .rx_level(rx_level), .irq_o(irq_o));

  typedef struct {
    int          due;
    logic [31:0] exp;
    logic        exp_irq;
    string       tag;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare queued expectations once the read data is registered
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if (reg_rdata !== it.exp || irq_o !== it.exp_irq) begin
        n_fail++;
        $display("FAIL %s rdata=%h exp=%h irq=%b exp_irq=%b",
                 it.tag, reg_rdata, it.exp, irq_o, it.exp_irq);
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input logic ei, input string tag);
    item_t it;
    reg_addr = a;
    it.due = cyc + 1; it.exp = exp; it.exp_irq = ei; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    #(20ns * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    hold(5);
    rst = 1'b0;
    // R1 reset state
    rd(0, 32'h0, 1'b0, "R1 status");
    rd(1, 32'h0, 1'b0, "R1 enable");
    rd(2, 32'h0, 1'b0, "R1 sigen");
    rd(3, 32'h0, 1'b0, "R1 thr");

    // R2, R3: sticky latch with masks off
    evt_desc_done = 1'b1; hold(1); evt_desc_done = 1'b0; hold(2);
    rd(0, 32'h200, 1'b0, "R2 R3 desc done sticky");
    evt_pkt_done = 1'b1; evt_dma_err = 1'b1; hold(1);
    evt_pkt_done = 1'b0; evt_dma_err = 1'b0; hold(1);
    rd(0, 32'hE00, 1'b0, "R2 pkt and err");
    rd(0, 32'hE00, 1'b0, "R12 reread");

    // R4 double gating
    wr(1, 32'h800);
    rd(1, 32'h800, 1'b0, "R4 enable only");
    wr(1, 32'h0); wr(2, 32'h800);
    rd(2, 32'h800, 1'b0, "R4 sigen only");
    wr(1, 32'h800);
    rd(0, 32'hE00, 1'b1, "R4 both masks");

    // R13 unmapped bits
    wr(1, 32'hFFFF_FFFF);
    rd(1, 32'hE3F, 1'b1, "R13 enable mask");
    wr(2, 32'hFFFF_FFFF);
    rd(2, 32'hE3F, 1'b1, "R13 sigen mask");

    // R7 silence by enable
    wr(1, 32'h0);
    rd(0, 32'hE00, 1'b0, "R7 enable cleared");
    wr(1, 32'hE3F);
    rd(0, 32'hE00, 1'b1, "R7 re-enabled");

    // R5 write-one-to-clear
    wr(0, 32'h0);
    rd(0, 32'hE00, 1'b1, "R5 zero write");
    wr(0, 32'h600);
    rd(0, 32'h800, 1'b1, "R5 partial clear");
    wr(0, 32'h800);
    rd(0, 32'h0, 1'b0, "R5 full clear");

    // R6 set beats clear
    evt_dma_err = 1'b1; wr(0, 32'h800); evt_dma_err = 1'b0;
    rd(0, 32'h800, 1'b1, "R6 same-cycle set");
    wr(0, 32'hFFF);

    // R8 empty and full
    tx_level = '0; hold(1); tx_level = LW'(5);
    rd(0, 32'h001, 1'b1, "R8 tx empty"); wr(0, 32'hFFF);
    tx_level = LW'(DEPTH); hold(1); tx_level = LW'(5);
    rd(0, 32'h002, 1'b1, "R8 tx full"); wr(0, 32'hFFF);
    rx_level = '0; hold(1); rx_level = LW'(3);
    rd(0, 32'h008, 1'b1, "R8 rx empty"); wr(0, 32'hFFF);
    rx_level = LW'(DEPTH); hold(1); rx_level = LW'(3);
    rd(0, 32'h010, 1'b1, "R8 rx full"); wr(0, 32'hFFF);

    // R10 zero thresholds and field layout
    tx_level = LW'(1); rx_level = LW'(15); hold(2);
    tx_level = LW'(5); rx_level = LW'(3);
    rd(0, 32'h0, 1'b0, "R10 zero thresholds");
    wr(3, 32'hFFFF_FFFF);
    rd(3, 32'h1F1F, 1'b0, "R10 field layout");
    wr(3, 32'h040A); wr(0, 32'hFFF);
    rd(0, 32'h0, 1'b0, "R10 thr written");

    // R9 inclusive thresholds
    rx_level = LW'(9); hold(2);
    rd(0, 32'h0, 1'b0, "R9 below edges");
    tx_level = LW'(4); hold(1); tx_level = LW'(5);
    rd(0, 32'h004, 1'b1, "R9 tx at thr"); wr(0, 32'hFFF);
    rx_level = LW'(10); hold(1); rx_level = LW'(9);
    rd(0, 32'h020, 1'b1, "R9 rx at thr"); wr(0, 32'hFFF);

    // R11 soft reset event
    evt_soft_rst = 1'b1; hold(1); evt_soft_rst = 1'b0; hold(1);
    rd(0, 32'h009, 1'b1, "R11 soft reset");

    hold(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule